// File: doc/BRIEF.md
# Interrupt Entry Stack Sequencer

This block carries out the entry path that an 8-bit accumulator-style processor follows when control leaves the running program. The four triggers are reset, a non-maskable interrupt, a maskable interrupt request and a software break opcode. For each trigger the block saves the return context on a stack that always stays in memory page 0x01. It then updates the stack pointer and the processor status, and reads a 16-bit handler address from a fixed table at the top of the address space. Ordinary instruction execution is not part of this block. A stub outside the block marks instruction boundaries, supplies the address of the next instruction and says whether that instruction is a break opcode. It can also clear the interrupt-disable flag.

Every entry is seven bus cycles long. Cycles 1 and 2 are fetches whose data is thrown away. Cycles 3 to 5 touch the stack. Cycles 6 and 7 read the low and then the high vector byte. For the one cycle after the last vector read, `vec_valid` is high and `handler_pc` holds the handler address. The memory bus has no wait states: `mem_rdata` must be valid in the cycle that `mem_addr` is presented. `busy` is high while reset is held and during every entry sequence.

Top module: `irq_entry_seq`

## Requirements
- R1: When `rst_n` is released, a reset entry runs. It makes no memory write, lowers SP from 0x00 to 0xFD, leaves status at 0x24 (interrupt-disable is bit 2, bit 5 is always 1), and takes the handler from 0xFFFC (low byte) and 0xFFFD (high byte). `vec_valid` rises after the 7th rising edge following release.
- R2: A non-reset entry makes exactly three writes, in cycles 3, 4 and 5. Each write goes to address 0x0100+SP, and SP drops by one after each write. SP wraps modulo 256, so the high address byte is always 0x01.
- R3: The bytes are pushed in the order return-PC high, return-PC low, status. The vector is read little-endian in cycles 6 and 7. `vec_valid` is a single-cycle pulse seen in the 8th cycle after the boundary edge that started the entry.
- R4: A break (`brk_op` high at `insn_end`) is taken whatever the state of the interrupt-disable flag. Its return address is the opcode address plus 2, modulo 65536. Its pushed status has bit 4 set. It uses vector 0xFFFE/0xFFFF.
- R5: An interrupt request is a low level on `irq_n`, sampled at `insn_end`. It is ignored while status bit 2 is 1. When taken, it pushes the boundary address with status bit 4 clear and uses vector 0xFFFE/0xFFFF.
- R6: Every entry leaves status bit 2 set. A pulse on `iflag_clr` while the block is idle clears that bit.
- R7: A falling edge on `nmi_n` is latched. At the next boundary the latched request wins over both break and interrupt request, pushes the boundary address with bit 4 clear, and uses vector 0xFFFA/0xFFFB. Holding `nmi_n` low does not cause a second entry.
- R8: If an NMI edge is latched by the end of cycle 4 of a break or IRQ entry, that entry switches to the NMI vector and keeps its own pushed status (bit 4 still set for a break), and the latched request is consumed. An edge that arrives in cycle 5 or later stays pending and is served at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release starts the reset entry |
| nmi_n | input | 1 | Non-maskable request, falling-edge triggered |
| irq_n | input | 1 | Maskable request, active-low level |
| insn_end | input | 1 | Instruction boundary strobe from the stub |
| brk_op | input | 1 | The instruction at `insn_pc` is a break opcode (valid with `insn_end`) |
| insn_pc | input | 16 | Address of the next instruction at the boundary |
| iflag_clr | input | 1 | Clears the interrupt-disable flag while idle |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_we | output | 1 | Bus write enable |
| mem_rdata | input | 8 | Bus read data, same cycle as the address |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Processor status byte |
| handler_pc | output | 16 | Handler address read from the vector table |
| vec_valid | output | 1 | One-cycle pulse when `handler_pc` is fresh |
| busy | output | 1 | Reset held or an entry sequence in progress |

## Verification
The hardest cases to reach are the NMI edges that land inside a break entry. The bench starts a break and drops `nmi_n` in a chosen cycle of the sequence. A drop in cycle 4 must redirect the entry to the NMI vector while the pushed break flag stays set. A drop in cycle 5 must leave the break untouched and produce a separate NMI entry at the next boundary. SP wraparound from 0x00 to 0xFF needs almost a hundred entries. A sweep alternates breaks and unmasked requests with varying addresses and vectors, and computes every expected stack address from a running SP model.

// File: rtl/irq_entry_seq.sv
`timescale 1ns/1ps
module irq_entry_seq #(
  parameter logic [7:0]  SP_INIT = 8'h00,
  parameter logic [7:0]  ST_INIT = 8'h24,
  parameter logic [15:0] NMI_VEC = 16'hFFFA,
  parameter logic [15:0] RST_VEC = 16'hFFFC,
  parameter logic [15:0] IRQ_VEC = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_n,
  input  logic        irq_n,
  input  logic        insn_end,
  input  logic        brk_op,
  input  logic [15:0] insn_pc,
  input  logic        iflag_clr,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  sp,
  output logic [7:0]  status,
  output logic [15:0] handler_pc,
  output logic        vec_valid,
  output logic        busy
);
  typedef enum logic [1:0] {K_RST, K_NMI, K_IRQ, K_BRK} kind_t;

  localparam int IFLAG = 2;
  localparam int BFLAG = 4;

  kind_t       kind;
  logic [2:0]  cyc;
  logic [15:0] fetch_pc, ret_pc;
  logic [7:0]  vec_lo;
  logic        use_nmi, nmi_q, nmi_pend;

  wire nmi_fall  = nmi_q & ~nmi_n;
  wire boundary  = !busy && insn_end;
  wire start_nmi = boundary && nmi_pend;
  wire start_brk = boundary && !nmi_pend && brk_op;
  wire start_irq = boundary && !nmi_pend && !brk_op && !irq_n && !status[IFLAG];
  wire start     = start_nmi | start_brk | start_irq;
  wire stack_cyc = busy && (cyc >= 3'd3) && (cyc <= 3'd5);
  wire take_nmi  = busy && (cyc == 3'd5) && (kind != K_RST) && nmi_pend;

  wire [7:0]  push_st  = {status[7:6], 1'b1, kind == K_BRK, status[3:0]};
  wire [15:0] vec_addr = use_nmi ? NMI_VEC : (kind == K_RST ? RST_VEC : IRQ_VEC);

  assign mem_we = stack_cyc && (kind != K_RST);

  always_comb begin
    mem_addr  = 16'h0000;
    mem_wdata = 8'h00;
    if (busy) begin
      case (cyc)
        3'd1:    mem_addr = fetch_pc;
        3'd2:    mem_addr = fetch_pc + 16'd1;
        3'd3:    begin mem_addr = {8'h01, sp}; mem_wdata = ret_pc[15:8]; end
        3'd4:    begin mem_addr = {8'h01, sp}; mem_wdata = ret_pc[7:0]; end
        3'd5:    begin mem_addr = {8'h01, sp}; mem_wdata = push_st; end
        3'd6:    mem_addr = vec_addr;
        3'd7:    mem_addr = vec_addr + 16'd1;
        default: mem_addr = 16'h0000;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b1;
      cyc        <= 3'd1;
      kind       <= K_RST;
      sp         <= SP_INIT;
      status     <= ST_INIT;
      fetch_pc   <= 16'h0000;
      ret_pc     <= 16'h0000;
      vec_lo     <= 8'h00;
      use_nmi    <= 1'b0;
      nmi_q      <= 1'b1;
      nmi_pend   <= 1'b0;
      handler_pc <= 16'h0000;
      vec_valid  <= 1'b0;
    end else begin
      nmi_q     <= nmi_n;
      nmi_pend  <= nmi_fall | (nmi_pend & ~take_nmi);
      vec_valid <= 1'b0;
      if (!busy) begin
        if (iflag_clr) status[IFLAG] <= 1'b0;
        if (start) begin
          busy     <= 1'b1;
          cyc      <= 3'd1;
          kind     <= start_nmi ? K_NMI : (start_brk ? K_BRK : K_IRQ);
          fetch_pc <= insn_pc;
          ret_pc   <= start_brk ? insn_pc + 16'd2 : insn_pc;
          use_nmi  <= 1'b0;
        end
      end else begin
        cyc <= cyc + 3'd1;
        if (stack_cyc) sp <= sp - 8'd1;
        if (cyc == 3'd5) begin
          status[IFLAG] <= 1'b1;
          status[BFLAG] <= 1'b0;
          status[5]     <= 1'b1;
          use_nmi       <= take_nmi;
        end
        if (cyc == 3'd6) vec_lo <= mem_rdata;
        if (cyc == 3'd7) begin
          handler_pc <= {mem_rdata, vec_lo};
          vec_valid  <= 1'b1;
          busy       <= 1'b0;
        end
      end
    end
  end
endmodule

module irq_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic [7:0]  sp,
  input logic [7:0]  status,
  input logic        vec_valid,
  input logic        busy,
  input logic [2:0]  cyc,
  input logic [1:0]  kind
);
  // R2
  stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == {8'h01, sp}));
  // R2
  sp_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp == $past(sp) - 8'd1));
  // R2
  idle_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(sp));
  // R3
  vv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  // R6
  iflag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> status[2]);
  // R1
  rst_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind == 2'd0) |-> !mem_we);
  // R4
  brk_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && kind == 2'd3 && cyc == 3'd5) |-> mem_wdata[4]);
  // R5
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && kind == 2'd2 && cyc == 3'd5) |-> !mem_wdata[4]);
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .sp(sp), .status(status), .vec_valid(vec_valid),
  .busy(busy), .cyc(cyc), .kind(kind)
);

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, nmi_n = 1'b1, irq_n = 1'b1;
  logic        insn_end = 1'b0, brk_op = 1'b0, iflag_clr = 1'b0;
  logic [15:0] insn_pc = 16'h0000;
  logic [15:0] mem_addr, handler_pc;
  logic [7:0]  mem_wdata, mem_rdata, sp, status;
  logic        mem_we, vec_valid, busy;

  logic [15:0] v_nmi = 16'h1234, v_rst = 16'hC0DE, v_irq = 16'hE5A7;

  always_comb begin
    case (mem_addr)
      16'hFFFA: mem_rdata = v_nmi[7:0];
      16'hFFFB: mem_rdata = v_nmi[15:8];
      16'hFFFC: mem_rdata = v_rst[7:0];
      16'hFFFD: mem_rdata = v_rst[15:8];
      16'hFFFE: mem_rdata = v_irq[7:0];
      16'hFFFF: mem_rdata = v_irq[15:8];
      default:  mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'h5A;
    endcase
  end

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_n(irq_n),
    .insn_end(insn_end), .brk_op(brk_op), .insn_pc(insn_pc), .iflag_clr(iflag_clr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .sp(sp), .status(status), .handler_pc(handler_pc), .vec_valid(vec_valid), .busy(busy)
  );

  int checks = 0, errors = 0;
  int ncyc, nw;
  logic [15:0] wa [3];
  logic [7:0]  wd [3];
  logic [7:0]  sp_m;
  logic        done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic b, input logic irq_lo, input logic [15:0] pc, input int nmi_at);
    @(negedge clk);
    insn_end = 1'b1; brk_op = b; insn_pc = pc; irq_n = ~irq_lo;
    @(negedge clk);
    insn_end = 1'b0; brk_op = 1'b0; irq_n = 1'b1;
    nw = 0; ncyc = 0;
    for (int c = 1; c <= 12; c++) begin
      if (c > 1) @(negedge clk);
      if (vec_valid) begin ncyc = c; break; end
      if (mem_we) begin
        if (nw < 3) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; end
        nw++;
      end
      if (c == nmi_at) nmi_n = 1'b0;
    end
  endtask

  task automatic verify(input string tag, input logic [15:0] ret, input logic [7:0] st,
                        input logic [15:0] hv);
    chk({tag, " R3 cycles"}, ncyc, 8);
    chk({tag, " R2 writes"}, nw, 3);
    for (int i = 0; i < 3; i++) chk({tag, " R2 addr"}, wa[i], {8'h01, sp_m - 8'(i)});
    chk({tag, " R3 pch"}, wd[0], ret[15:8]);
    chk({tag, " R3 pcl"}, wd[1], ret[7:0]);
    chk({tag, " status pushed"}, wd[2], st);
    sp_m = sp_m - 8'd3;
    chk({tag, " R2 sp"}, sp, sp_m);
    chk({tag, " R3 vector"}, handler_pc, hv);
    chk({tag, " R6 iflag"}, status[2], 1);
    @(negedge clk);
    chk({tag, " R3 pulse"}, vec_valid, 0);
  endtask

  task automatic expect_idle(input string tag);
    chk({tag, " no entry"}, ncyc, 0);
    chk({tag, " no write"}, nw, 0);
    chk({tag, " sp kept"}, sp, sp_m);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset sp", sp, 8'h00);
    chk("R1 reset we", mem_we, 0);
    chk("R1 reset vv", vec_valid, 0);
    rst_n = 1'b1;
    n = 0; nw = 0;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      if (vec_valid) begin n = c; break; end
      if (mem_we) nw++;
    end
    chk("R1 reset timing", n, 7);
    chk("R1 reset no writes", nw, 0);
    chk("R1 reset sp", sp, 8'hFD);
    chk("R1 reset status", status, 8'h24);
    chk("R1 reset vector", handler_pc, v_rst);
    sp_m = 8'hFD;

    fire(1, 0, 16'h1000, 0);
    verify("R4 brk masked", 16'h1002, 8'h34, v_irq);

    fire(0, 1, 16'h3000, 0);
    expect_idle("R5 irq masked");

    @(negedge clk); iflag_clr = 1'b1;
    @(negedge clk); iflag_clr = 1'b0;
    chk("R6 iflag clear", status, 8'h20);
    fire(0, 1, 16'h2345, 0);
    verify("R5 irq taken", 16'h2345, 8'h20, v_irq);
    chk("R6 status after", status, 8'h24);

    @(negedge clk); nmi_n = 1'b0;
    @(negedge clk);
    fire(1, 1, 16'h4000, 0);
    verify("R7 nmi priority", 16'h4000, 8'h24, v_nmi);
    fire(0, 0, 16'h4100, 0);
    expect_idle("R7 held low");
    @(negedge clk); nmi_n = 1'b1;

    fire(1, 0, 16'h5000, 4);
    verify("R8 hijack", 16'h5002, 8'h34, v_nmi);
    @(negedge clk); nmi_n = 1'b1;
    fire(0, 0, 16'h5100, 0);
    expect_idle("R8 consumed");

    fire(1, 0, 16'h6000, 5);
    verify("R8 late edge", 16'h6002, 8'h34, v_irq);
    @(negedge clk); nmi_n = 1'b1;
    fire(0, 0, 16'h6100, 0);
    verify("R8 pending served", 16'h6100, 8'h24, v_nmi);

    fire(1, 0, 16'hFFFE, 0);
    verify("R4 pc wrap", 16'h0000, 8'h34, v_irq);

    for (int k = 0; k < 90; k++) begin
      logic [15:0] pc;
      pc = 16'(k) * 16'h0F3D + 16'h0011;
      v_irq = 16'(k) * 16'h0707 + 16'h8001;
      if (k % 2 == 0) begin
        fire(1, 0, pc, 0);
        verify("R2 sweep brk", pc + 16'd2, 8'h34, v_irq);
      end else begin
        @(negedge clk); iflag_clr = 1'b1;
        @(negedge clk); iflag_clr = 1'b0;
        fire(0, 1, pc, 0);
        verify("R2 sweep irq", pc, 8'h20, v_irq);
      end
    end

    summary();
  end
endmodule